// File: doc/BRIEF.md
# Two-Cell Transmit Cell Buffer

This block sits between a segmentation unit and the transmit framer. The upstream side pushes 53-byte cells over an 8-bit bus. It asserts a write enable for every byte and a one-cycle start strobe together with the first byte of each cell. The buffer stores up to two whole cells. It reports through a "space available" flag whether one more cell may be started. The upstream side polls that flag before it begins a cell.

On the framer side, a cell becomes visible only once all 53 of its bytes have arrived. Its bytes are offered one at a time under a valid/ready handshake, with a marker on the first byte of each cell. Cells leave in the order they were completed. A cell that is cut short by a new start strobe is dropped and never reaches the framer. Bytes written while no cell is open are thrown away.

Top module: `cell_tx_buffer`

## Requirements
- R1: After reset `space_ok` is 1 and `rd_valid` is 0.
- R2: A cell opens on a cycle with `wr_en`=1 and `wr_soc`=1, and that byte is cell byte 0. Each later cycle with `wr_en`=1 and `wr_soc`=0 stores the next byte. Cycles with `wr_en`=0 store nothing and do not advance the byte position.
- R3: A cell is offered to the reader only after its 53rd byte is stored. `rd_valid` stays 0 while only 52 bytes of the oldest cell are present, and it rises on the cycle after the 53rd byte is written.
- R4: The reader receives the 53 bytes in write order, with `rd_soc`=1 on byte 0 only. A byte is consumed only on a cycle with `rd_valid`=1 and `rd_ready`=1. While `rd_ready`=0, `rd_data` and `rd_soc` hold.
- R5: A start strobe that arrives before the open cell has 53 bytes discards the partial cell and opens a new one in the same slot. Only the new cell is delivered.
- R6: A byte written while no cell is open is ignored. This covers bytes written after a cell has completed and `wr_soc`=1 without `wr_en`. Such bytes change neither `space_ok` nor anything delivered.
- R7: `space_ok` drops to 0 on the cycle after the second cell is opened, counting both complete and in-progress cells. It returns to 1 on the cycle after the reader consumes the last byte of a cell.
- R8: A start strobe while two cells are held is ignored, as are the bytes that follow it. The held cells are delivered unchanged.
- R9: Cells are delivered in the order they completed. Writing a new cell while an older one is being read corrupts neither of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock for both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_data | input | 8 | Byte from the segmentation unit |
| wr_en | input | 1 | Byte on `wr_data` is valid this cycle |
| wr_soc | input | 1 | Current byte is byte 0 of a cell |
| space_ok | output | 1 | High when another cell may be started |
| rd_data | output | 8 | Byte offered to the framer |
| rd_soc | output | 1 | Offered byte is byte 0 of a cell |
| rd_valid | output | 1 | A complete cell is available and `rd_data` is valid |
| rd_ready | input | 1 | Framer takes the offered byte this cycle |

## Verification
A wrong write byte index shows up within one cell as shifted or missing bytes in the delivered cell. It also shows up as `rd_valid` rising one cycle early or late relative to the 53rd write. A corrupt cell count or slot pointer shows up at the ports within two cells. It appears as `space_ok` holding the wrong level after a cell opens or drains, as a ghost cell offered after the buffer should be empty, or as a newer cell arriving ahead of an older one. Stalls on `rd_ready` in the middle of a cell expose a read pointer that moves without a handshake on the very next sample.

// File: rtl/cell_buf_pkg.sv
package cell_buf_pkg;

  // Flat storage address of byte idx in cell slot slot.
  function automatic int cell_addr(int slot, int idx, int cell_bytes);
    return slot * cell_bytes + idx;
  endfunction

  // Ring advance over the cell slots.
  function automatic int next_slot(int slot, int num_cells);
    return (slot + 1 >= num_cells) ? 0 : slot + 1;
  endfunction

  // Cells taking space: finished ones plus the one being filled.
  function automatic int occupancy(int done_cells, bit filling);
    return done_cells + (filling ? 1 : 0);
  endfunction

endpackage

// File: rtl/cell_store.sv
module cell_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 106,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/cell_wr_ctrl.sv
module cell_wr_ctrl
  import cell_buf_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int NUM_CELLS  = 2,
  localparam int DEPTH  = CELL_BYTES * NUM_CELLS,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int IDX_W  = (CELL_BYTES > 1) ? $clog2(CELL_BYTES) : 1,
  localparam int SLOT_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_soc,
  input  logic              room,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              filling,
  output logic              cell_commit
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  logic [IDX_W-1:0]  byte_idx;
  logic [SLOT_W-1:0] wr_slot;
  logic              start_ok;
  logic              cont_ok;

  // A start is taken whenever a finished slot is free; an open cell
  // already owns a free slot, so a restart always lands in place.
  assign start_ok    = wr_en && wr_soc && room;
  assign cont_ok     = wr_en && !wr_soc && filling;
  assign mem_we      = start_ok || cont_ok;
  assign cell_commit = cont_ok && (byte_idx == LAST_IDX);
  assign mem_addr    = ADDR_W'(cell_addr(int'(wr_slot),
                                         start_ok ? 0 : int'(byte_idx),
                                         CELL_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filling  <= 1'b0;
      byte_idx <= '0;
      wr_slot  <= '0;
    end else if (start_ok) begin
      filling  <= 1'b1;
      byte_idx <= IDX_W'(1);
    end else if (cell_commit) begin
      filling  <= 1'b0;
      byte_idx <= '0;
      wr_slot  <= SLOT_W'(next_slot(int'(wr_slot), NUM_CELLS));
    end else if (cont_ok) begin
      byte_idx <= byte_idx + IDX_W'(1);
    end
  end

  assert_commit_full_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cell_commit |-> (filling && byte_idx == LAST_IDX));

  assert_orphan_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!filling && wr_en && !wr_soc) |-> !mem_we);

  assert_restart_in_place_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (filling && wr_en && wr_soc) |=> (filling && byte_idx == IDX_W'(1) && $stable(wr_slot)));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(byte_idx) && $stable(filling)));

endmodule

// File: rtl/cell_rd_ctrl.sv
module cell_rd_ctrl
  import cell_buf_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int NUM_CELLS  = 2,
  localparam int DEPTH  = CELL_BYTES * NUM_CELLS,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int IDX_W  = (CELL_BYTES > 1) ? $clog2(CELL_BYTES) : 1,
  localparam int SLOT_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              have_cell,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic              rd_soc,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cell_done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  logic [IDX_W-1:0]  rd_idx;
  logic [SLOT_W-1:0] rd_slot;
  logic              take;

  assign rd_valid  = have_cell;
  assign rd_soc    = have_cell && (rd_idx == '0);
  assign take      = rd_valid && rd_ready;
  assign cell_done = take && (rd_idx == LAST_IDX);
  assign rd_addr   = ADDR_W'(cell_addr(int'(rd_slot), int'(rd_idx), CELL_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx  <= '0;
      rd_slot <= '0;
    end else if (cell_done) begin
      rd_idx  <= '0;
      rd_slot <= SLOT_W'(next_slot(int'(rd_slot), NUM_CELLS));
    end else if (take) begin
      rd_idx <= rd_idx + IDX_W'(1);
    end
  end

  assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(rd_soc)));

  assert_soc_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_soc |-> rd_valid);

  assert_soc_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_done && have_cell) |=> (!rd_valid || rd_soc));

endmodule

// File: rtl/cell_tx_buffer.sv
module cell_tx_buffer
  import cell_buf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  parameter int NUM_CELLS  = 2,
  localparam int DEPTH  = CELL_BYTES * NUM_CELLS,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(NUM_CELLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              wr_soc,
  output logic              space_ok,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_soc,
  output logic              rd_valid,
  input  logic              rd_ready
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_CELLS);

  logic [CNT_W-1:0]  done_cnt;
  logic              room;
  logic              filling;
  logic              cell_commit;
  logic              cell_done;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [ADDR_W-1:0] mem_raddr;

  assign room     = done_cnt < FULL_CNT;
  assign space_ok = occupancy(int'(done_cnt), filling) < NUM_CELLS;

  always_ff @(posedge clk) begin
    if (!rst_n) done_cnt <= '0;
    else        done_cnt <= done_cnt + CNT_W'(cell_commit) - CNT_W'(cell_done);
  end

  cell_wr_ctrl #(
    .CELL_BYTES (CELL_BYTES),
    .NUM_CELLS  (NUM_CELLS)
  ) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_soc      (wr_soc),
    .room        (room),
    .mem_we      (mem_we),
    .mem_addr    (mem_waddr),
    .filling     (filling),
    .cell_commit (cell_commit)
  );

  cell_rd_ctrl #(
    .CELL_BYTES (CELL_BYTES),
    .NUM_CELLS  (NUM_CELLS)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .have_cell (done_cnt != '0),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_soc    (rd_soc),
    .rd_addr   (mem_raddr),
    .cell_done (cell_done)
  );

  cell_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (wr_data),
    .raddr (mem_raddr),
    .rdata (rd_data)
  );

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cell_commit |-> (done_cnt < FULL_CNT));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cell_done |-> (done_cnt != '0));

  assert_full_blocks_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_cnt == FULL_CNT) |-> !mem_we);

  assert_space_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_commit && !cell_done && done_cnt == FULL_CNT - CNT_W'(1)) |=> !space_ok);

  assert_space_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_done && !filling && !cell_commit && !(wr_en && wr_soc)) |=> space_ok);

endmodule

// File: tb/cell_tx_buffer_test.sv
module cell_tx_buffer_test;

  localparam int CLK_PERIOD = 10;
  localparam int CB = 53;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_en = 1'b0;
  logic       wr_soc = 1'b0;
  logic       space_ok;
  logic [7:0] rd_data;
  logic       rd_soc;
  logic       rd_valid;
  logic       rd_ready = 1'b0;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cell_tx_buffer uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_data  (wr_data),
    .wr_en    (wr_en),
    .wr_soc   (wr_soc),
    .space_ok (space_ok),
    .rd_data  (rd_data),
    .rd_soc   (rd_soc),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Writes count bytes base, base+1, ...; start strobe on the first only.
  // A wr_en=0 cycle is inserted before byte gap_at when gap_at >= 0.
  task automatic send_bytes(int base, int count, int gap_at);
    for (int i = 0; i < count; i++) begin
      if (i == gap_at) begin
        @(negedge clk);
        wr_en = 1'b0; wr_soc = 1'b0;
      end
      @(negedge clk);
      wr_en = 1'b1; wr_soc = (i == 0); wr_data = 8'(base + i);
    end
    @(negedge clk);
    wr_en = 1'b0; wr_soc = 1'b0;
  endtask

  // Reads one cell from a negedge; checks every byte and the soc marker.
  task automatic recv_cell(int base, int stall_at, string req);
    for (int i = 0; i < CB; i++) begin
      check(rd_valid === 1'b1, req, int'(rd_valid), 1);
      check(rd_data === 8'(base + i), req, int'(rd_data), int'(8'(base + i)));
      check(rd_soc === (i == 0), req, int'(rd_soc), int'(i == 0));
      if (i == stall_at) begin
        rd_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(rd_data === 8'(base + i), "R4 stall hold", int'(rd_data), int'(8'(base + i)));
        check(rd_soc === (i == 0), "R4 stall soc", int'(rd_soc), int'(i == 0));
      end
      rd_ready = 1'b1;
      @(negedge clk);
    end
    rd_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(space_ok === 1'b1, "R1 space_ok", int'(space_ok), 1);
    check(rd_valid === 1'b0, "R1 rd_valid", int'(rd_valid), 0);
  endtask

  task automatic t_single;
    send_bytes(8'h10, CB - 1, 20);
    check(rd_valid === 1'b0, "R3 52 bytes not visible", int'(rd_valid), 0);
    wr_en = 1'b1; wr_soc = 1'b0; wr_data = 8'(8'h10 + CB - 1);
    @(negedge clk);
    wr_en = 1'b0;
    check(rd_valid === 1'b1, "R3 visible after 53rd", int'(rd_valid), 1);
    recv_cell(8'h10, 7, "R2 R4 single cell");
    check(rd_valid === 1'b0, "R4 drained", int'(rd_valid), 0);
    check(space_ok === 1'b1, "R7 empty space", int'(space_ok), 1);
  endtask

  task automatic t_full;
    send_bytes(8'h20, CB, -1);
    check(space_ok === 1'b1, "R7 one cell space", int'(space_ok), 1);
    @(negedge clk);
    wr_en = 1'b1; wr_soc = 1'b1; wr_data = 8'h60;
    @(negedge clk);
    wr_en = 1'b0; wr_soc = 1'b0;
    check(space_ok === 1'b0, "R7 low on second open", int'(space_ok), 0);
    for (int i = 1; i < CB; i++) begin
      wr_en = 1'b1; wr_data = 8'(8'h60 + i);
      @(negedge clk);
    end
    wr_en = 1'b0;
    check(space_ok === 1'b0, "R7 low when two held", int'(space_ok), 0);
    send_bytes(8'hA0, CB, -1);
    check(space_ok === 1'b0, "R8 still low", int'(space_ok), 0);
    recv_cell(8'h20, -1, "R8 R9 first held");
    check(space_ok === 1'b1, "R7 returns after drain", int'(space_ok), 1);
    recv_cell(8'h60, 30, "R8 R9 second held");
    check(rd_valid === 1'b0, "R8 rejected cell absent", int'(rd_valid), 0);
  endtask

  task automatic t_restart;
    send_bytes(8'h40, 20, -1);
    check(rd_valid === 1'b0, "R5 partial hidden", int'(rd_valid), 0);
    send_bytes(8'h80, CB, -1);
    recv_cell(8'h80, -1, "R5 new cell");
    check(rd_valid === 1'b0, "R5 partial dropped", int'(rd_valid), 0);
  endtask

  task automatic t_orphan;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_soc = 1'b0; wr_data = 8'(i);
    end
    @(negedge clk);
    wr_en = 1'b0; wr_soc = 1'b1;
    @(negedge clk);
    wr_soc = 1'b0;
    @(negedge clk);
    check(rd_valid === 1'b0, "R6 orphans no cell", int'(rd_valid), 0);
    check(space_ok === 1'b1, "R6 orphans no space", int'(space_ok), 1);
    send_bytes(8'hC0, CB + 10, -1);
    check(space_ok === 1'b1, "R6 trailing bytes ignored", int'(space_ok), 1);
    recv_cell(8'hC0, -1, "R6 cell intact");
    check(rd_valid === 1'b0, "R6 no extra cell", int'(rd_valid), 0);
  endtask

  task automatic t_overlap;
    send_bytes(8'h05, CB, -1);
    fork
      send_bytes(8'h90, CB, 10);
      recv_cell(8'h05, 3, "R9 read during write");
    join
    @(negedge clk);
    recv_cell(8'h90, -1, "R9 second in order");
    check(rd_valid === 1'b0, "R9 drained", int'(rd_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_full();
    t_restart();
    t_orphan();
    t_overlap();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule